// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block models the device side of a 16-kbit serial EEPROM that a host reaches over three wires: a select line, a shift clock and a serial data input, plus one serial data output with its own enable. The select, shift clock and data input come from outside the chip's clock domain. They pass through a synchronizer clocked by the system clock, and every shift-clock rising edge seen after it moves one bit through the frame logic. The host starts each instruction by raising the select line. The instruction is a start bit, a two-bit operation code and an address, and for programming commands a data field follows.

A static strap input picks the array shape. When it is high the array is 1024 words of 16 bits. When it is low it is 2048 bytes. Programming is refused after reset until an enable command arrives. Programming takes a parameterized number of system clocks, and during that time the block ignores new instructions. A host that re-raises the select line while programming runs reads the busy or ready state on the data output. Reads can run on as a burst, address after address, for as long as the select line stays high.

Top module: `tw_eeprom_dev`

## Requirements
- R1: A frame is a start bit of 1 (zeros before it are skipped), a two-bit operation code and then the address MSB first. The address is 11 bits with `word_mode_i` low and 10 bits with it high. Codes: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 special.
- R2: For code 2'b00 the two highest address bits choose the command: 2'b11 enables programming, 2'b00 disables it, 2'b10 erases the whole array, 2'b01 fills the whole array with the data that follows. The lower address bits are ignored.
- R3: On a read, the shift-clock rise that captures the last address bit drives a dummy 0. Each later rise then presents the next data bit, MSB first: 8 bits per byte, or 16 per word.
- R4: While the select line stays high, a read goes on to the next address with no further dummy bit. After the last location (2047 bytes or 1023 words) it wraps to 0.
- R5: In word mode, word w occupies byte 2w as its low half and byte 2w+1 as its high half.
- R6: Programming is disabled after reset and after the disable command, and is enabled by the enable command. A refused programming command leaves the array unchanged and starts no busy period. Reads work in both states.
- R7: Write stores its data field in the addressed location with no prior erase needed. Erase sets every bit of the addressed location to 1.
- R8: Array erase sets every bit of the array to 1. Array fill stores the data field in every location.
- R9: If the select line is raised while programming runs, the output is enabled and drives 0 until programming ends, then 1, until the select line falls. If the select line is raised when nothing is running, the output stays disabled.
- R10: Any instruction shifted in while programming runs, or during a status phase, is ignored.
- R11: The output enable is low except during read data or status. It drops within three clocks after the select line falls.
- R12: Busy lasts `PROG_CYCLES` clocks after the start of programming. An array-wide operation also stays busy for at least one clock per location written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Select line from host, active high, asynchronous |
| sclk_i | input | 1 | Serial shift clock from host, asynchronous |
| sdi_i | input | 1 | Serial data from host, captured on shift-clock rise |
| word_mode_i | input | 1 | Array shape strap: 1 = 16-bit words, 0 = bytes |
| sdo_o | output | 1 | Serial data or ready/busy status |
| sdo_en_o | output | 1 | Output enable for `sdo_o` (0 = high impedance) |

## Verification
A shift-clock rise reaches the frame logic two clocks after it appears at the pin and is acted on at the third clock edge. The data output therefore changes about three clocks after each rise. The bench holds each shift-clock phase for six clocks and samples the output at the end of the low phase, which reads the bit produced by the previous rise. Busy starts about four clocks after the last data bit, and ready is due `PROG_CYCLES` clocks after that, or after the array sweep for array-wide operations. The bench counts clocks from its own select rise and checks the count against a window derived from those latencies. The output enable is checked four clocks after the select line falls, one clock after the synchronizer has passed the fall through.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int BYTE_AW = 11;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    SP_LOCK   = 2'b00,
    SP_FILL   = 2'b01,
    SP_CLEAR  = 2'b10,
    SP_UNLOCK = 2'b11
  } special_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_OPCODE, FR_ADDR, FR_DATA, FR_READ, FR_HOLD
  } frame_state_e;

  typedef enum logic [1:0] {
    PK_ONE_WRITE, PK_ONE_ERASE, PK_ALL_WRITE, PK_ALL_ERASE
  } prog_kind_e;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= async_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_byte_array.sv
module tw_byte_array #(
  parameter int BYTE_AW = 11,
  parameter int BYTE_W  = 8
) (
  input  logic                clk,
  input  logic                we_i,
  input  logic                wide_i,
  input  logic [BYTE_AW-1:0]  waddr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [BYTE_AW-1:0]  raddr_i,
  output logic [2*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << BYTE_AW;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      if (wide_i) begin
        cells[{waddr_i[BYTE_AW-1:1], 1'b0}] <= wdata_i[BYTE_W-1:0];
        cells[{waddr_i[BYTE_AW-1:1], 1'b1}] <= wdata_i[2*BYTE_W-1:BYTE_W];
      end else begin
        cells[waddr_i] <= wdata_i[BYTE_W-1:0];
      end
    end
  end

  always_comb begin
    if (wide_i)
      rdata_o = {cells[{raddr_i[BYTE_AW-1:1], 1'b1}], cells[{raddr_i[BYTE_AW-1:1], 1'b0}]};
    else
      rdata_o = {{BYTE_W{1'b0}}, cells[raddr_i]};
  end
endmodule

// File: rtl/tw_prog_engine.sv
module tw_prog_engine
  import tw_eeprom_pkg::*;
#(
  parameter int BYTE_AW     = 11,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 3000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  prog_kind_e         kind_i,
  input  logic [BYTE_AW-1:0] addr_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic               wide_i,
  output logic               busy_o,
  output logic               we_o,
  output logic               wide_o,
  output logic [BYTE_AW-1:0] waddr_o,
  output logic [WORD_W-1:0]  wdata_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [BYTE_AW-1:0] LAST_BYTE = '1;

  logic [CNT_W-1:0]   timer_q;
  logic               single_q;
  logic               sweep_q;
  logic               wide_q;
  logic [BYTE_AW-1:0] ptr_q;
  logic [WORD_W-1:0]  fill_q;
  logic [BYTE_AW-1:0] sweep_last;
  logic [BYTE_AW-1:0] sweep_step;
  logic               is_all;
  logic               is_erase;

  assign is_all     = (kind_i == PK_ALL_WRITE) || (kind_i == PK_ALL_ERASE);
  assign is_erase   = (kind_i == PK_ONE_ERASE) || (kind_i == PK_ALL_ERASE);
  assign sweep_step = wide_q ? BYTE_AW'(2) : BYTE_AW'(1);
  assign sweep_last = wide_q ? (LAST_BYTE - BYTE_AW'(1)) : LAST_BYTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q  <= '0;
      single_q <= 1'b0;
      sweep_q  <= 1'b0;
      wide_q   <= 1'b0;
      ptr_q    <= '0;
      fill_q   <= '0;
    end else if (start_i) begin
      timer_q  <= CNT_W'(PROG_CYCLES);
      wide_q   <= wide_i;
      fill_q   <= is_erase ? '1 : data_i;
      single_q <= !is_all;
      sweep_q  <= is_all;
      if (is_all)      ptr_q <= '0;
      else if (wide_i) ptr_q <= {addr_i[BYTE_AW-2:0], 1'b0};
      else             ptr_q <= addr_i;
    end else begin
      if (timer_q != '0) timer_q <= timer_q - 1'b1;
      single_q <= 1'b0;
      if (sweep_q) begin
        if (ptr_q == sweep_last) sweep_q <= 1'b0;
        else                     ptr_q   <= ptr_q + sweep_step;
      end
    end
  end

  assign busy_o  = (timer_q != '0) || single_q || sweep_q;
  assign we_o    = single_q || sweep_q;
  assign wide_o  = wide_q;
  assign waddr_o = ptr_q;
  assign wdata_o = fill_q;
endmodule

// File: rtl/tw_frame_ctrl.sv
module tw_frame_ctrl
  import tw_eeprom_pkg::*;
#(
  parameter int BYTE_AW = 11,
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_lvl_i,
  input  logic               sclk_lvl_i,
  input  logic               sdi_lvl_i,
  input  logic               word_mode_i,
  input  logic               busy_i,
  input  logic [WORD_W-1:0]  rd_word_i,
  output logic [BYTE_AW-1:0] rd_addr_o,
  output logic               start_o,
  output prog_kind_e         kind_o,
  output logic [BYTE_AW-1:0] paddr_o,
  output logic [WORD_W-1:0]  pdata_o,
  output logic               unlocked_o,
  output logic               sdo_o,
  output logic               sdo_en_o
);
  localparam int BC_W  = $clog2((WORD_W > BYTE_AW) ? WORD_W : BYTE_AW);
  localparam int IDX_W = $clog2(WORD_W);

  frame_state_e       state_q;
  logic               sel_prev_q, sclk_prev_q;
  logic [BC_W-1:0]    bitcnt_q;
  logic [1:0]         opc_q;
  logic [BYTE_AW-1:0] sr_q;
  logic [WORD_W-1:0]  dsr_q;
  logic               unlocked_q, status_q, reading_q, sdo_q;
  logic [BYTE_AW-1:0] rd_ptr_q;
  logic [IDX_W-1:0]   rd_idx_q;

  logic               sel_rise, sclk_rise;
  logic [BC_W-1:0]    aw_last, dw_last;
  logic [IDX_W-1:0]   idx_top;
  logic [BYTE_AW-1:0] sr_next, addr_new, addr_held, ptr_inc;
  logic [WORD_W-1:0]  dsr_next, data_new;
  special_e           sub_cmd;

  assign sel_rise  = sel_lvl_i & ~sel_prev_q;
  assign sclk_rise = sclk_lvl_i & ~sclk_prev_q;
  assign aw_last   = word_mode_i ? BC_W'(BYTE_AW - 2) : BC_W'(BYTE_AW - 1);
  assign dw_last   = word_mode_i ? BC_W'(WORD_W - 1)  : BC_W'(BYTE_W - 1);
  assign idx_top   = word_mode_i ? IDX_W'(WORD_W - 1) : IDX_W'(BYTE_W - 1);
  assign sr_next   = {sr_q[BYTE_AW-2:0], sdi_lvl_i};
  assign dsr_next  = {dsr_q[WORD_W-2:0], sdi_lvl_i};
  assign addr_new  = word_mode_i ? {1'b0, sr_next[BYTE_AW-2:0]} : sr_next;
  assign addr_held = word_mode_i ? {1'b0, sr_q[BYTE_AW-2:0]} : sr_q;
  assign data_new  = word_mode_i ? dsr_next
                                 : {{(WORD_W-BYTE_W){1'b0}}, dsr_next[BYTE_W-1:0]};
  assign sub_cmd   = word_mode_i ? special_e'(sr_next[BYTE_AW-2:BYTE_AW-3])
                                 : special_e'(sr_next[BYTE_AW-1:BYTE_AW-2]);

  always_comb begin
    ptr_inc = rd_ptr_q + 1'b1;
    if (word_mode_i) ptr_inc[BYTE_AW-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FR_IDLE;
      sel_prev_q  <= 1'b0;
      sclk_prev_q <= 1'b0;
      bitcnt_q    <= '0;
      opc_q       <= '0;
      sr_q        <= '0;
      dsr_q       <= '0;
      unlocked_q  <= 1'b0;
      status_q    <= 1'b0;
      reading_q   <= 1'b0;
      sdo_q       <= 1'b0;
      rd_ptr_q    <= '0;
      rd_idx_q    <= '0;
      start_o     <= 1'b0;
      kind_o      <= PK_ONE_WRITE;
      paddr_o     <= '0;
      pdata_o     <= '0;
    end else begin
      sel_prev_q  <= sel_lvl_i;
      sclk_prev_q <= sclk_lvl_i;
      start_o     <= 1'b0;
      if (!sel_lvl_i) begin
        state_q   <= FR_IDLE;
        status_q  <= 1'b0;
        reading_q <= 1'b0;
      end else begin
        if (sel_rise && busy_i) status_q <= 1'b1;
        if (sclk_rise) begin
          unique case (state_q)
            FR_IDLE: begin
              bitcnt_q <= '0;
              if (sdi_lvl_i && !busy_i && !status_q) state_q <= FR_OPCODE;
            end
            FR_OPCODE: begin
              opc_q    <= {opc_q[0], sdi_lvl_i};
              bitcnt_q <= bitcnt_q + 1'b1;
              if (bitcnt_q == BC_W'(1)) begin
                state_q  <= FR_ADDR;
                bitcnt_q <= '0;
              end
            end
            FR_ADDR: begin
              sr_q     <= sr_next;
              bitcnt_q <= bitcnt_q + 1'b1;
              if (bitcnt_q == aw_last) begin
                bitcnt_q <= '0;
                state_q  <= FR_HOLD;
                unique case (opcode_e'(opc_q))
                  OP_READ: begin
                    state_q   <= FR_READ;
                    reading_q <= 1'b1;
                    sdo_q     <= 1'b0;
                    rd_ptr_q  <= addr_new;
                    rd_idx_q  <= idx_top;
                  end
                  OP_WRITE: state_q <= FR_DATA;
                  OP_ERASE: begin
                    start_o <= unlocked_q;
                    kind_o  <= PK_ONE_ERASE;
                    paddr_o <= addr_new;
                  end
                  OP_SPECIAL: begin
                    unique case (sub_cmd)
                      SP_UNLOCK: unlocked_q <= 1'b1;
                      SP_LOCK:   unlocked_q <= 1'b0;
                      SP_CLEAR: begin
                        start_o <= unlocked_q;
                        kind_o  <= PK_ALL_ERASE;
                      end
                      SP_FILL:   state_q <= FR_DATA;
                    endcase
                  end
                endcase
              end
            end
            FR_DATA: begin
              dsr_q    <= dsr_next;
              bitcnt_q <= bitcnt_q + 1'b1;
              if (bitcnt_q == dw_last) begin
                state_q <= FR_HOLD;
                start_o <= unlocked_q;
                kind_o  <= (opcode_e'(opc_q) == OP_WRITE) ? PK_ONE_WRITE : PK_ALL_WRITE;
                paddr_o <= addr_held;
                pdata_o <= data_new;
              end
            end
            FR_READ: begin
              sdo_q <= rd_word_i[rd_idx_q];
              if (rd_idx_q == '0) begin
                rd_idx_q <= idx_top;
                rd_ptr_q <= ptr_inc;
              end else begin
                rd_idx_q <= rd_idx_q - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_addr_o  = word_mode_i ? {rd_ptr_q[BYTE_AW-2:0], 1'b0} : rd_ptr_q;
  assign unlocked_o = unlocked_q;
  assign sdo_en_o   = sel_lvl_i & (reading_q | status_q);
  assign sdo_o      = status_q ? ~busy_i : sdo_q;
endmodule

// File: rtl/tw_eeprom_dev.sv
module tw_eeprom_dev
  import tw_eeprom_pkg::*;
#(
  parameter int PROG_CYCLES = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic word_mode_i,
  output logic sdo_o,
  output logic sdo_en_o
);
  logic [2:0]         pins_lvl;
  logic               sel_lvl;
  logic               prog_busy, prog_start, write_unlocked;
  prog_kind_e         prog_kind;
  logic [BYTE_AW-1:0] prog_addr, rd_addr, mem_waddr;
  logic [WORD_W-1:0]  prog_data, rd_word, mem_wdata;
  logic               mem_we, mem_wide;

  tw_pin_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sel_i, sclk_i, sdi_i}),
    .level_o (pins_lvl)
  );

  assign sel_lvl = pins_lvl[2];

  tw_frame_ctrl #(.BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_lvl_i   (sel_lvl),
    .sclk_lvl_i  (pins_lvl[1]),
    .sdi_lvl_i   (pins_lvl[0]),
    .word_mode_i (word_mode_i),
    .busy_i      (prog_busy),
    .rd_word_i   (rd_word),
    .rd_addr_o   (rd_addr),
    .start_o     (prog_start),
    .kind_o      (prog_kind),
    .paddr_o     (prog_addr),
    .pdata_o     (prog_data),
    .unlocked_o  (write_unlocked),
    .sdo_o       (sdo_o),
    .sdo_en_o    (sdo_en_o)
  );

  tw_prog_engine #(.BYTE_AW(BYTE_AW), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (prog_start),
    .kind_i  (prog_kind),
    .addr_i  (prog_addr),
    .data_i  (prog_data),
    .wide_i  (word_mode_i),
    .busy_o  (prog_busy),
    .we_o    (mem_we),
    .wide_o  (mem_wide),
    .waddr_o (mem_waddr),
    .wdata_o (mem_wdata)
  );

  tw_byte_array #(.BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W)) u_array (
    .clk     (clk),
    .we_i    (mem_we),
    .wide_i  (mem_we ? mem_wide : word_mode_i),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk #(
  parameter int PROG_CYCLES = 3000
) (
  input logic clk,
  input logic rst_n,
  input logic sel_lvl,
  input logic sdo,
  input logic sdo_en,
  input logic busy,
  input logic start,
  input logic unlocked
);
  logic [31:0] since_start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_start_q <= '0;
    else if (start)                     since_start_q <= '0;
    else if (since_start_q != '1)       since_start_q <= since_start_q + 1'b1;
  end

  p_en_needs_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> sel_lvl);

  p_first_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> !sdo);

  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  p_start_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> unlocked);

  p_busy_length_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (since_start_q >= 32'(PROG_CYCLES)));
endmodule

bind tw_eeprom_dev tw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_lvl  (sel_lvl),
  .sdo      (sdo_o),
  .sdo_en   (sdo_en_o),
  .busy     (prog_busy),
  .start    (prog_start),
  .unlocked (write_unlocked)
);

// File: tb/test_tw_eeprom_dev.sv
module test_tw_eeprom_dev;
  localparam int PROG = 600;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, wm = 1'b0;
  logic sdo, sdo_en;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tw_eeprom_dev #(.PROG_CYCLES(PROG), .SYNC_STAGES(2)) i_tw_eeprom_dev (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .word_mode_i(wm), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_up();
    @(negedge clk); sel = 1'b1; wait_clk(HALF);
  endtask

  task automatic sel_down();
    @(negedge clk); sel = 1'b0; sclk = 1'b0; wait_clk(HALF);
  endtask

  task automatic sbit(input logic b, output logic o);
    @(negedge clk); sdi = b;
    wait_clk(HALF);
    o = sdo;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) sbit(v[i], o);
  endtask

  task automatic frame(input logic [1:0] opc, input logic [10:0] addr);
    sel_up();
    send(16'd1, 1);
    send({14'd0, opc}, 2);
    send({5'd0, addr}, wm ? 10 : 11);
  endtask

  task automatic special(input logic [1:0] sub);
    frame(2'b00, wm ? {1'b0, sub, 8'h00} : {sub, 9'h000});
  endtask

  task automatic wait_ready(input string req, output int cyc);
    sel_down();
    sel_up();
    chk(req, "status enable", 32'(sdo_en), 32'd1);
    chk(req, "busy level", 32'(sdo), 32'd0);
    cyc = 0;
    while (sdo !== 1'b1 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    sel_down();
  endtask

  task automatic prog_one(input string req, input logic [1:0] opc, input logic [10:0] a,
                          input logic [15:0] d);
    int cyc;
    frame(opc, a);
    if (opc == 2'b01) send(d, wm ? 16 : 8);
    wait_ready(req, cyc);
    chk(req, "single busy window", 32'(cyc > 540 && cyc < 600), 32'd1);
  endtask

  task automatic read_run(input string req, input logic [10:0] a, input int n,
                          input logic [15:0] e0, input logic [15:0] e1,
                          input logic [15:0] e2);
    logic o;
    logic [15:0] got;
    logic [15:0] exp [3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    frame(2'b10, a);
    sbit(1'b0, o);
    chk("R3", "dummy bit", 32'(o), 32'd0);
    chk("R11", "enable during read", 32'(sdo_en), 32'd1);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int i = 0; i < (wm ? 16 : 8); i++) begin
        sbit(1'b0, o);
        got = {got[14:0], o};
      end
      chk(req, $sformatf("read word %0d", w), 32'(got), 32'(exp[w]));
    end
    @(negedge clk); sel = 1'b0; sclk = 1'b0;
    wait_clk(4);
    chk("R11", "enable after drop", 32'(sdo_en), 32'd0);
    wait_clk(2);
  endtask

  task automatic t_reset();
    chk("R11", "enable in reset", 32'(sdo_en), 32'd0);
    sel_up();
    chk("R11", "enable idle selected", 32'(sdo_en), 32'd0);
    sel_down();
  endtask

  task automatic t_locked_write();
    frame(2'b01, 11'h005);
    send(16'h0012, 8);
    sel_down();
    sel_up();
    chk("R6", "no busy when locked", 32'(sdo_en), 32'd0);
    sel_down();
  endtask

  task automatic t_erase_all();
    int cyc;
    special(2'b11);
    sel_down();
    special(2'b10);
    wait_ready("R9", cyc);
    chk("R12", "array erase sweep time", 32'(cyc > 1950 && cyc < 2200), 32'd1);
    sel_up();
    chk("R9", "no status when idle", 32'(sdo_en), 32'd0);
    sel_down();
    read_run("R8", 11'h7FF, 3, 16'h00FF, 16'h00FF, 16'h00FF);
    read_run("R6", 11'h005, 1, 16'h00FF, 16'h0, 16'h0);
  endtask

  task automatic t_byte_write_burst();
    prog_one("R7", 2'b01, 11'h123, 16'h00A5);
    read_run("R7", 11'h123, 1, 16'h00A5, 16'h0, 16'h0);
    prog_one("R7", 2'b01, 11'h00A, 16'h003C);
    prog_one("R7", 2'b01, 11'h00B, 16'h00C3);
    read_run("R4", 11'h00A, 3, 16'h003C, 16'h00C3, 16'h00FF);
    prog_one("R7", 2'b11, 11'h00A, 16'h0000);
    read_run("R7", 11'h009, 3, 16'h00FF, 16'h00FF, 16'h00C3);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    frame(2'b01, 11'h014);
    send(16'h0011, 8);
    sel_down();
    sel_up();
    frame(2'b01, 11'h015);
    send(16'h0022, 8);
    wait_ready("R10", cyc);
    read_run("R10", 11'h014, 2, 16'h0011, 16'h00FF, 16'h0);
  endtask

  task automatic t_lock_again();
    special(2'b00);
    sel_down();
    frame(2'b01, 11'h123);
    send(16'h0000, 8);
    sel_down();
    sel_up();
    chk("R6", "no busy after lock", 32'(sdo_en), 32'd0);
    sel_down();
    frame(2'b11, 11'h123);
    sel_down();
    read_run("R6", 11'h123, 1, 16'h00A5, 16'h0, 16'h0);
  endtask

  task automatic t_word_mode();
    int cyc;
    wm = 1'b1;
    wait_clk(2);
    special(2'b11);
    sel_down();
    prog_one("R1", 2'b01, 11'h055, 16'hBEEF);
    read_run("R1", 11'h055, 1, 16'hBEEF, 16'h0, 16'h0);
    prog_one("R7", 2'b01, 11'h3FF, 16'h1234);
    prog_one("R7", 2'b01, 11'h000, 16'h5678);
    read_run("R4", 11'h3FF, 2, 16'h1234, 16'h5678, 16'h0);
    wm = 1'b0;
    wait_clk(2);
    read_run("R5", 11'h0AA, 2, 16'h00EF, 16'h00BE, 16'h0);
    wm = 1'b1;
    wait_clk(2);
    prog_one("R7", 2'b11, 11'h055, 16'h0000);
    read_run("R7", 11'h055, 1, 16'hFFFF, 16'h0, 16'h0);
    special(2'b01);
    send(16'hA55A, 16);
    wait_ready("R9", cyc);
    chk("R12", "array fill sweep time", 32'(cyc > 950 && cyc < 1150), 32'd1);
    read_run("R8", 11'h2BC, 2, 16'hA55A, 16'hA55A, 16'h0);
    wm = 1'b0;
    wait_clk(2);
    read_run("R2", 11'h578, 2, 16'h005A, 16'h00A5, 16'h0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_locked_write();
    t_erase_all();
    t_byte_write_burst();
    t_busy_ignore();
    t_lock_again();
    t_word_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule